// File: doc/BRIEF.md
# Glitch-Free Clock Prescaler

This block divides a fast main clock by a power-of-two ratio and drives the resulting system clock. The output is a registered toggle, so it never glitches. Software may rewrite the ratio select at any moment. The new value is captured at once, but it reaches the divider only at a safe handover point. That point is the main-clock edge where the output rises, at the end of a complete low phase under the old ratio. Because of this, every high and low phase of the output is exactly half of either the old period or the new one. No shortened or over-fast cycle appears during the change.

A status output stays high while a captured ratio is still waiting for its handover edge. A write that lands while another is still pending replaces it, and the handover applies only the latest value. The internal reset asserts asynchronously and releases synchronously to the main clock. After reset the output runs at divide-by-8.

Top module: `prescale_glitchfree`

## Requirements
- R1: During reset `sys_clk` and `switch_pending` are low. After reset, until the first write, each high phase and each low phase lasts 4 main-clock cycles (divide-by-8, select code 2).
- R2: A select code N from 0 to 7 gives division by 2^(N+1). Codes 8 to 15 all give division by 256.
- R3: In steady state, every high phase and every low phase of `sys_clk` lasts exactly half the division ratio, counted in main-clock cycles.
- R4: A write (`wr_en` high at a main-clock edge) captures `sel`. `switch_pending` is high from that edge onward until the handover.
- R5: The handover happens only at a main-clock edge where `sys_clk` rises, and at no later than one old output period (T1 main-clock cycles) after the write edge. `switch_pending` falls on that same edge. The first new-ratio period therefore completes no later than T1+T2 after the write.
- R6: Each phase of `sys_clk` equals either the old half-period or the new one. No phase is shorter than the shorter of the two.
- R7: A write made while a switch is pending replaces the captured value. Only the most recent select is applied at the handover.
- R8: A write sampled on the same edge as a handover does not take effect then. The value already pending is applied on that edge, and the new value stays pending until the following rising edge of `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock that runs the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a new ratio select |
| sel | input | 4 | Ratio select code (see R2) |
| sys_clk | output | 1 | Divided system clock |
| switch_pending | output | 1 | High while a captured ratio waits for its handover edge |

## Verification
The hardest case to reach from the ports is a write that coincides with the handover edge itself (R8), because the internal count is not visible. The stimulus aligns to a rising edge of `sys_clk`. Since the period is known, it then counts main-clock cycles and places the second write so that it is sampled exactly on the next rising edge. A scoreboard measures every phase length and tracks the pending flag, so the handover order is checked cycle by cycle.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  // Map a select code onto the log2 of the half period, saturating at the top.
  function automatic int unsigned clamp_hl(input int unsigned code, input int unsigned hl_max);
    return (code > hl_max) ? hl_max : code;
  endfunction

endpackage

// File: rtl/prescale_rst_sync.sv
module prescale_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/prescale_sel_latch.sv
module prescale_sel_latch #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned HL_W      = 3,
  parameter int unsigned HL_MAX    = 7,
  parameter int unsigned RESET_SEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             rise,
  output logic             pend,
  output logic [HL_W-1:0]  act_hl
);

  localparam logic [HL_W-1:0] RESET_HL = HL_W'(prescale_pkg::clamp_hl(RESET_SEL, HL_MAX));

  logic [HL_W-1:0] pend_hl;
  logic [HL_W-1:0] hl_dec;
  logic            pend_nxt;
  logic [HL_W-1:0] pend_hl_nxt;
  logic [HL_W-1:0] act_hl_nxt;

  always_comb begin
    hl_dec      = HL_W'(prescale_pkg::clamp_hl({{(32-SEL_W){1'b0}}, sel}, HL_MAX));
    pend_hl_nxt = wr_en ? hl_dec : pend_hl;
    // A new write wins over the clear that a handover would do.
    if (wr_en) begin
      pend_nxt = 1'b1;
    end else if (rise) begin
      pend_nxt = 1'b0;
    end else begin
      pend_nxt = pend;
    end
    act_hl_nxt = (rise && pend) ? pend_hl : act_hl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      pend_hl <= RESET_HL;
      act_hl  <= RESET_HL;
    end else begin
      pend    <= pend_nxt;
      pend_hl <= pend_hl_nxt;
      act_hl  <= act_hl_nxt;
    end
  end

endmodule

// File: rtl/prescale_phase_ctr.sv
module prescale_phase_ctr #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned HL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HL_W-1:0]  act_hl,
  output logic             out,
  output logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] term
);

  logic             tc;
  logic [CNT_W-1:0] cnt_nxt;
  logic             out_nxt;

  always_comb begin
    // Half period is 2^act_hl; the shift wraps to zero at the top code, which the subtraction fixes.
    term    = (CNT_W'(1) << act_hl) - CNT_W'(1);
    tc      = (cnt == term);
    cnt_nxt = tc ? '0 : cnt + CNT_W'(1);
    out_nxt = out ^ tc;
    rise    = tc & ~out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      out <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      out <= out_nxt;
    end
  end

endmodule

// File: rtl/prescale_glitchfree.sv
module prescale_glitchfree #(
  parameter int unsigned SEL_W         = 4,
  parameter int unsigned MAX_RATIO_LOG = 8,
  parameter int unsigned RESET_SEL     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  output logic             sys_clk,
  output logic             switch_pending
);

  localparam int unsigned HL_MAX = MAX_RATIO_LOG - 1;
  localparam int unsigned HL_W   = (HL_MAX > 0) ? $clog2(HL_MAX + 1) : 1;
  localparam int unsigned CNT_W  = (HL_MAX > 0) ? HL_MAX : 1;

  logic             rst_int_n;
  logic             rise;
  logic             pend;
  logic [HL_W-1:0]  act_hl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             out;

  prescale_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  prescale_sel_latch #(
    .SEL_W     (SEL_W),
    .HL_W      (HL_W),
    .HL_MAX    (HL_MAX),
    .RESET_SEL (RESET_SEL)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .rise   (rise),
    .pend   (pend),
    .act_hl (act_hl)
  );

  prescale_phase_ctr #(
    .CNT_W (CNT_W),
    .HL_W  (HL_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .act_hl (act_hl),
    .out    (out),
    .rise   (rise),
    .cnt    (cnt),
    .term   (term)
  );

  assign sys_clk        = out;
  assign switch_pending = pend;

endmodule

// File: rtl/prescale_glitchfree_chk.sv
module prescale_glitchfree_chk #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned HL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             sys_clk,
  input logic             switch_pending,
  input logic [HL_W-1:0]  act_hl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] term
);

  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> switch_pending);

  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(switch_pending) |-> $rose(sys_clk));

  p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sys_clk) |-> $stable(act_hl));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(switch_pending) |-> $stable(act_hl));

  p_fresh_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_hl) |-> (sys_clk && cnt == '0));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= term);

endmodule

bind prescale_glitchfree prescale_glitchfree_chk #(
  .CNT_W (CNT_W),
  .HL_W  (HL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .wr_en          (wr_en),
  .sys_clk        (sys_clk),
  .switch_pending (switch_pending),
  .act_hl         (act_hl),
  .cnt            (cnt),
  .term           (term)
);

// File: tb/prescale_glitchfree_test.sv
module prescale_glitchfree_test;

  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 150000;

  typedef struct {
    int edge_idx;
    int half;
  } wr_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] sel = 4'd0;
  wire        sys_clk;
  wire        switch_pending;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;
  wr_item_t wq[$];

  // Scoreboard state
  bit armed = 1'b0;
  bit prev_out;
  int run;
  int exp_half = 4;
  bit m_pend = 1'b0;
  int m_pend_half = 0;
  int last_wr = 0;

  prescale_glitchfree uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .sel            (sel),
    .sys_clk        (sys_clk),
    .switch_pending (switch_pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) ecount <= ecount + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int half_of(input int code);
    return (code > 7) ? 128 : (1 << code);
  endfunction

  task automatic do_write(input int code);
    @(negedge clk);
    wr_en = 1'b1;
    sel   = 4'(code);
    wq.push_back('{ecount + 1, half_of(code)});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (switch_pending) @(negedge clk);
  endtask

  task automatic measure_high(output int n);
    n = 0;
    @(posedge sys_clk);
    forever begin
      @(negedge clk);
      if (sys_clk) n++;
      else break;
    end
  endtask

  // Monitor: measures every phase and tracks the expected pending state.
  always @(negedge clk) begin
    if (!armed) begin
      if (rst_n && sys_clk) begin
        armed    = 1'b1;
        prev_out = 1'b1;
        run      = 1;
      end
    end else begin
      if (sys_clk != prev_out) begin
        // R3 R6: each phase is exactly the half period in force
        check(run == exp_half, "R3 R6", "phase length", run, exp_half);
        if (sys_clk && m_pend) begin
          // R5: handover no later than one old period after the write
          check((ecount - last_wr) >= 1 && (ecount - last_wr) <= 2 * exp_half,
                "R5", "handover latency", ecount - last_wr, 2 * exp_half);
          exp_half = m_pend_half;
          m_pend   = 1'b0;
        end
        run = 1;
      end else begin
        run++;
      end
      prev_out = sys_clk;
      if (wq.size() > 0 && wq[0].edge_idx == ecount) begin
        m_pend      = 1'b1;
        m_pend_half = wq[0].half;
        last_wr     = ecount;
        void'(wq.pop_front());
      end
      // R4 R7: pending flag follows the capture and handover rules
      check(switch_pending == m_pend, "R4 R7", "switch_pending", int'(switch_pending), int'(m_pend));
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(sys_clk == 1'b0, "R1", "sys_clk in reset", int'(sys_clk), 0);
    check(switch_pending == 1'b0, "R1", "pending in reset", int'(switch_pending), 0);
    rst_n = 1'b1;

    // R1: default divide-by-8
    measure_high(n);
    check(n == 4, "R1", "default high phase", n, 4);

    // R2: smallest ratio
    do_write(0);
    wait_idle();
    measure_high(n);
    check(n == 1, "R2", "code 0 high phase", n, 1);

    // R2: largest regular code
    do_write(7);
    wait_idle();
    measure_high(n);
    check(n == 128, "R2", "code 7 high phase", n, 128);

    // R2: reserved codes saturate
    do_write(12);
    wait_idle();
    measure_high(n);
    check(n == 128, "R2", "code 12 high phase", n, 128);

    do_write(3);
    wait_idle();
    measure_high(n);
    check(n == 8, "R2", "code 3 high phase", n, 8);

    // R7: second write replaces the pending one
    @(posedge sys_clk);
    do_write(6);
    check(switch_pending == 1'b1, "R7", "pending after first write", int'(switch_pending), 1);
    do_write(1);
    wait_idle();
    measure_high(n);
    check(n == 2, "R7", "latest value applied", n, 2);

    // R8: write that coincides with the handover edge
    do_write(4);
    wait_idle();
    @(posedge sys_clk);
    @(negedge clk);
    wr_en = 1'b1;
    sel   = 4'd5;
    wq.push_back('{ecount + 1, half_of(5)});
    @(negedge clk);
    wr_en = 1'b0;
    repeat (29) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    sel   = 4'd0;
    wq.push_back('{ecount + 1, half_of(0)});
    @(negedge clk);
    wr_en = 1'b0;
    check(sys_clk == 1'b1, "R8", "rise on handover edge", int'(sys_clk), 1);
    check(switch_pending == 1'b1, "R8", "new value still pending", int'(switch_pending), 1);
    n = 1;
    forever begin
      @(negedge clk);
      if (sys_clk) n++;
      else break;
    end
    check(n == 32, "R8", "earlier value applied first", n, 32);
    wait_idle();
    measure_high(n);
    check(n == 1, "R8", "later value applied next", n, 1);

    repeat (200) @(negedge clk);
    summary();
    $finish;
  end

endmodule